// File: doc/BRIEF.md
# Descriptor List Index Sequencer

This block tells a DMA engine which buffer descriptor to use next, walking a circular list whose length software sets. Software uses a small register interface to program the highest valid entry of the list and to start or stop the walk. While the walk is active, the block presents the current descriptor index. Each single-cycle completion pulse from the engine moves the index forward by one. After the highest valid entry, the index returns to zero.

The block guards its own configuration. It refuses to start when the list would hold only one entry, and records that refusal in a sticky error flag. It keeps the programmed bound fixed while the walk is active. A stopped walk holds its index, and every start begins again at entry zero.

Top module: `desc_idx_seq`

## Requirements
- R1: After reset, the bound, the run flag, the error flag, the current index and the wrap pulse are all 0, and both registers read as 0.
- R2: A write with `wr_addr`=0 while stopped stores `wr_data[7:0]` as the bound and ignores bits 15:8. A read of address 0 returns the bound in bits 7:0 with bits 15:8 zero, one cycle after `rd_addr` is presented.
- R3: While running, each `done_i` pulse increments `cur_idx_o` by one in the following cycle, provided the index is below the bound. The index never exceeds the bound while running.
- R4: A `done_i` pulse while `cur_idx_o` equals the bound returns the index to 0 and raises `wrap_o` for exactly one cycle. `wrap_o` is 0 at all other times.
- R5: `done_i` pulses while stopped leave `cur_idx_o` unchanged.
- R6: A write to address 0 while running leaves the bound unchanged.
- R7: A write with `wr_addr`=1 and bit 0 set, made while stopped, starts the walk and sets the index to 0 if the bound is at least 1. If the bound is 0, run stays 0 and the error flag is set.
- R8: The error flag stays set until a write to address 1 with bit 1 set clears it. A read of address 1 returns run in bit 0 and the error flag in bit 1, with all other bits zero.
- R9: A write to address 1 with bit 0 clear stops the walk, and the index stays frozen until the next start.
- R10: A `done_i` pulse in the same cycle as a stop write is still counted. A `done_i` pulse in the same cycle as a start write is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write target: 0 bound, 1 control |
| wr_data | input | 16 | Write data |
| rd_addr | input | 1 | Read target: 0 bound, 1 control |
| rd_data | output | 16 | Registered read data |
| done_i | input | 1 | Single-cycle descriptor-complete pulse |
| run_o | output | 1 | Walk active |
| err_o | output | 1 | Sticky refused-start flag |
| cur_idx_o | output | 8 | Current descriptor index |
| wrap_o | output | 1 | One-cycle pulse on return to entry 0 |

## Verification
A completion pulse can arrive in the same cycle as a control write that stops or starts the walk. The bench provokes both cases. It issues a stop write together with `done_i`, and expects the index to advance once and then hold. It issues a start write together with `done_i`, and expects the index to be 0 with no advance. The scoreboard derives every expected value from the run state as it stood before that clock edge.

// File: rtl/desc_idx_pkg.sv
package desc_idx_pkg;
  typedef enum logic {
    ADDR_BOUND = 1'b0,
    ADDR_CTRL  = 1'b1
  } reg_addr_e;

  localparam int CTRL_RUN_BIT = 0;
  localparam int CTRL_ERR_BIT = 1;
endpackage

// File: rtl/desc_idx_regs.sv
module desc_idx_regs
  import desc_idx_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [IDX_W-1:0]  bound_o,
  output logic              run_o,
  output logic              err_o,
  output logic              start_o
);
  localparam int PAD_W = DATA_W - IDX_W;

  logic [IDX_W-1:0]  bound_q;
  logic              run_q;
  logic              err_q;
  logic              wr_bound;
  logic              wr_ctrl;
  logic              run_req;
  logic              bound_ok;
  logic              start_bad;
  logic [DATA_W-1:0] ctrl_word;
  logic              unused_wr_hi;

  assign wr_bound  = wr_en && (wr_addr == ADDR_BOUND);
  assign wr_ctrl   = wr_en && (wr_addr == ADDR_CTRL);
  assign run_req   = wr_data[CTRL_RUN_BIT];
  assign bound_ok  = (bound_q != '0);
  assign start_o   = wr_ctrl && run_req && !run_q && bound_ok;
  assign start_bad = wr_ctrl && run_req && !run_q && !bound_ok;
  assign unused_wr_hi = ^wr_data[DATA_W-1:IDX_W];

  always_comb begin
    ctrl_word = '0;
    ctrl_word[CTRL_RUN_BIT] = run_q;
    ctrl_word[CTRL_ERR_BIT] = err_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bound_q <= '0;
      run_q   <= 1'b0;
      err_q   <= 1'b0;
      rd_data <= '0;
    end else begin
      if (wr_bound && !run_q) bound_q <= wr_data[IDX_W-1:0];
      if (wr_ctrl) run_q <= run_req && (run_q || bound_ok);
      if (start_bad) err_q <= 1'b1;
      else if (wr_ctrl && wr_data[CTRL_ERR_BIT]) err_q <= 1'b0;
      if (rd_addr == ADDR_CTRL) rd_data <= ctrl_word;
      else rd_data <= {{PAD_W{1'b0}}, bound_q};
    end
  end

  assign bound_o = bound_q;
  assign run_o   = run_q;
  assign err_o   = err_q;
endmodule

// File: rtl/desc_idx_ctr.sv
module desc_idx_ctr #(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  logic             start_i,
  input  logic             done_i,
  input  logic [IDX_W-1:0] bound_i,
  output logic [IDX_W-1:0] cur_o,
  output logic             wrap_o
);
  logic at_end;
  assign at_end = (cur_o == bound_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_o  <= '0;
      wrap_o <= 1'b0;
    end else begin
      wrap_o <= 1'b0;
      if (start_i) begin
        cur_o <= '0;
      end else if (run_i && done_i) begin
        if (at_end) begin
          cur_o  <= '0;
          wrap_o <= 1'b1;
        end else begin
          cur_o <= cur_o + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/desc_idx_seq.sv
module desc_idx_seq #(
  parameter int IDX_W  = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              done_i,
  output logic              run_o,
  output logic              err_o,
  output logic [IDX_W-1:0]  cur_idx_o,
  output logic              wrap_o
);
  logic [IDX_W-1:0] bound_q;
  logic             start_w;

  desc_idx_regs #(.IDX_W(IDX_W), .DATA_W(DATA_W)) i_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .bound_o(bound_q), .run_o(run_o),
    .err_o(err_o), .start_o(start_w)
  );

  desc_idx_ctr #(.IDX_W(IDX_W)) i_ctr (
    .clk(clk), .rst(rst), .run_i(run_o), .start_i(start_w), .done_i(done_i),
    .bound_i(bound_q), .cur_o(cur_idx_o), .wrap_o(wrap_o)
  );
endmodule

// File: rtl/desc_idx_seq_chk.sv
module desc_idx_seq_chk #(
  parameter int IDX_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             run_o,
  input logic             wrap_o,
  input logic [IDX_W-1:0] cur_idx_o,
  input logic [IDX_W-1:0] bound_q
);
  assert_bound_locked_R6: assert property (@(posedge clk) disable iff (rst)
    run_o |=> $stable(bound_q));

  assert_start_legal_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(run_o) |-> (bound_q != '0));

  assert_start_zero_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(run_o) |-> (cur_idx_o == '0));

  assert_wrap_R4: assert property (@(posedge clk) disable iff (rst)
    wrap_o |-> (cur_idx_o == '0) && ($past(cur_idx_o) == $past(bound_q)) && $past(run_o));

  assert_frozen_R9: assert property (@(posedge clk) disable iff (rst)
    (!run_o && !$past(run_o)) |-> $stable(cur_idx_o));

  assert_in_range_R3: assert property (@(posedge clk) disable iff (rst)
    run_o |-> (cur_idx_o <= bound_q));
endmodule

bind desc_idx_seq desc_idx_seq_chk #(.IDX_W(IDX_W)) i_chk (
  .clk(clk), .rst(rst), .run_o(run_o), .wrap_o(wrap_o),
  .cur_idx_o(cur_idx_o), .bound_q(bound_q)
);

// File: tb/test_desc_idx_seq.sv
module test_desc_idx_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        wr_addr = 1'b0;
  logic [15:0] wr_data = '0;
  logic        rd_addr = 1'b0;
  logic [15:0] rd_data;
  logic        done_i = 1'b0;
  logic        run_o;
  logic        err_o;
  logic [7:0]  cur_idx_o;
  logic        wrap_o;

  always #4 clk = ~clk;

  desc_idx_seq i_desc_idx_seq (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .done_i(done_i), .run_o(run_o),
    .err_o(err_o), .cur_idx_o(cur_idx_o), .wrap_o(wrap_o)
  );

  typedef struct {
    logic        run;
    logic [7:0]  cur;
    logic        wrap;
    logic        err;
    logic [15:0] rd;
    string       tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int failures = 0;

  logic [7:0] m_bound = '0;
  logic       m_run = 1'b0;
  logic       m_err = 1'b0;
  logic [7:0] m_cur = '0;

  task automatic step(input logic we, input logic addr, input logic [15:0] data,
                      input logic done, input logic raddr, input string tag);
    exp_t e;
    logic [7:0] cur_n;
    logic wrap_n;
    logic wctl;
    @(negedge clk);
    wr_en = we; wr_addr = addr; wr_data = data; done_i = done; rd_addr = raddr;
    e.rd = raddr ? {14'b0, m_err, m_run} : {8'b0, m_bound};
    cur_n = m_cur; wrap_n = 1'b0;
    wctl = we && addr;
    if (m_run && done) begin
      if (m_cur == m_bound) begin cur_n = 8'd0; wrap_n = 1'b1; end
      else cur_n = m_cur + 8'd1;
    end
    if (wctl && data[0] && !m_run && m_bound != 0) cur_n = 8'd0;
    if (wctl && data[0] && !m_run && m_bound == 0) m_err = 1'b1;
    else if (wctl && data[1]) m_err = 1'b0;
    if (we && !addr && !m_run) m_bound = data[7:0];
    if (wctl) m_run = data[0] && (m_run || m_bound != 0);
    m_cur = cur_n;
    e.run = m_run; e.cur = m_cur; e.wrap = wrap_n; e.err = m_err; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic idle(input int n, input logic raddr, input string tag);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 16'h0, 1'b0, raddr, tag);
  endtask

  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (run_o !== e.run || cur_idx_o !== e.cur || wrap_o !== e.wrap ||
          err_o !== e.err || rd_data !== e.rd) begin
        failures++;
        $display("FAIL %s: got run=%0b cur=%0d wrap=%0b err=%0b rd=%h exp run=%0b cur=%0d wrap=%0b err=%0b rd=%h",
                 e.tag, run_o, cur_idx_o, wrap_o, err_o, rd_data,
                 e.run, e.cur, e.wrap, e.err, e.rd);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: got hung run exp completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    checks++;
    // R1 reset state
    if (run_o !== 1'b0 || err_o !== 1'b0 || cur_idx_o !== 8'd0 || wrap_o !== 1'b0 || rd_data !== 16'h0) begin
      failures++;
      $display("FAIL R1: got run=%0b err=%0b cur=%0d wrap=%0b rd=%h exp all zero",
               run_o, err_o, cur_idx_o, wrap_o, rd_data);
    end
    idle(1, 1'b1, "R1 ctrl read");
    idle(1, 1'b0, "R1 bound read");
    step(1'b0, 1'b0, 16'h0, 1'b1, 1'b0, "R5 done while stopped");
    step(1'b0, 1'b0, 16'h0, 1'b1, 1'b0, "R5 done while stopped");
    step(1'b1, 1'b1, 16'h0001, 1'b0, 1'b1, "R7 refused start");
    idle(2, 1'b1, "R8 error sticky");
    step(1'b1, 1'b1, 16'h0000, 1'b0, 1'b1, "R8 no clear without bit1");
    step(1'b1, 1'b1, 16'h0002, 1'b0, 1'b1, "R8 clear error");
    idle(1, 1'b1, "R8 cleared read");
    step(1'b1, 1'b0, 16'hAB03, 1'b0, 1'b0, "R2 bound write");
    idle(1, 1'b0, "R2 bound read");
    step(1'b1, 1'b1, 16'h0001, 1'b0, 1'b1, "R7 legal start");
    idle(1, 1'b1, "R7 run read");
    step(1'b0, 1'b0, 16'h0, 1'b1, 1'b0, "R3 advance");
    idle(1, 1'b0, "R3 hold");
    step(1'b0, 1'b0, 16'h0, 1'b1, 1'b0, "R3 advance");
    step(1'b0, 1'b0, 16'h0, 1'b1, 1'b0, "R3 advance");
    step(1'b0, 1'b0, 16'h0, 1'b1, 1'b0, "R4 wrap");
    idle(1, 1'b0, "R4 wrap one cycle");
    step(1'b1, 1'b0, 16'h0007, 1'b0, 1'b0, "R6 write while running");
    idle(1, 1'b0, "R6 bound unchanged");
    for (int i = 0; i < 9; i++) step(1'b0, 1'b0, 16'h0, 1'b1, 1'b0, "R4 back-to-back");
    step(1'b1, 1'b1, 16'h0000, 1'b1, 1'b1, "R10 done with stop");
    step(1'b0, 1'b0, 16'h0, 1'b1, 1'b1, "R9 frozen after stop");
    idle(2, 1'b1, "R9 frozen");
    step(1'b1, 1'b0, 16'h0001, 1'b0, 1'b0, "R2 bound one");
    idle(1, 1'b0, "R2 bound read");
    step(1'b1, 1'b1, 16'h0001, 1'b1, 1'b1, "R10 done with start");
    step(1'b0, 1'b0, 16'h0, 1'b1, 1'b0, "R3 advance short list");
    step(1'b0, 1'b0, 16'h0, 1'b1, 1'b0, "R4 wrap short list");
    step(1'b0, 1'b0, 16'h0, 1'b1, 1'b0, "R3 advance after wrap");
    step(1'b1, 1'b1, 16'h0000, 1'b0, 1'b1, "R9 stop");
    step(1'b1, 1'b0, 16'h0000, 1'b0, 1'b0, "R2 bound zero");
    step(1'b1, 1'b1, 16'h0001, 1'b0, 1'b1, "R7 refused again");
    idle(2, 1'b1, "R8 sticky");
    step(1'b1, 1'b1, 16'h0003, 1'b0, 1'b1, "R7 refused with clear");
    idle(1, 1'b1, "R8 set wins");
    idle(3, 1'b0, "drain");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule